// File: doc/BRIEF.md
# Banked Eight-Port Serial Register Decoder

This block is the host-facing register file of an eight-channel serial controller. A 16-bit host bus reaches it with byte-wide data on the low lane. The block decodes the word address into a channel index and a register slot. It then resolves each slot, and the register it names, from the direction of the access and from the line-control byte stored for that channel. The channel's control bytes are held here. These are line control, interrupt enable, modem control, scratch, the two divisor bytes, the enhanced-feature byte and the two flow-control character pairs. The stored values go out on flat configuration buses to the rest of the controller.

Data movement and status belong to logic outside this block. For those slots the block only routes the access. A read of the receive-data slot returns the channel's receive-byte input and pulses that channel's receive-pop strobe. A write to the transmit slot or the FIFO-control slot pulses a per-channel strobe, and the write byte appears on a shared output. Reads of interrupt status, line status and modem status return the channel's status inputs.

Visibility depends on the stored line-control byte. Setting its top bit swaps the divisor bytes into slots 0 and 1. The exact value 0xBF also swaps in the enhanced bank at slots 2, 4, 5, 6 and 7. Byte-lane bit A0 is not an input: the host bus leaves it unconnected, so even and odd byte lanes decode alike.

Top module: `uart_bank_regfile`

## Requirements
- R1: After reset every stored control byte of every channel reads 0x00, and all configuration outputs are 0.
- R2: The channel index is taken from address bits A6..A4 and the slot from A3..A1, so channel p, slot k sits at byte address 0x10*p + 2*k. A write changes only the addressed channel, and only one strobe output is active at a time.
- R3: With line-control bit 7 clear, a read of slot 0 returns the channel's receive-byte input and pulses bit p of `rx_pop_o`. A write to slot 0 pulses bit p of `tx_push_o` and presents the byte on `tx_byte_o`.
- R4: With line-control bit 7 set, including the value 0xBF, slots 0 and 1 read and write the divisor low and high bytes. These appear on `cfg_div_o`, high byte in bits 15..8, and no transmit-push or receive-pop strobe fires.
- R5: With line-control bit 7 clear, slot 1 reads and writes the interrupt-enable byte.
- R6: Outside the 0xBF bank, a read of slot 2 returns the interrupt-status input and a write pulses bit p of `fifo_wr_o`. With line control at 0xBF, slot 2 reads and writes the enhanced-feature byte and no FIFO strobe fires.
- R7: Slot 3 always reads and writes the line-control byte, whatever the bank state.
- R8: Outside the 0xBF bank, slot 4 reads and writes modem control, and slot 5 reads the line-status input, with writes there ignored. With 0xBF, slots 4 and 5 hold the first and second XON bytes, which appear on `cfg_xon_o`, second byte in bits 15..8.
- R9: Outside the 0xBF bank, slot 6 reads the modem-status input, with writes ignored, and slot 7 is the scratch byte. With 0xBF, slots 6 and 7 hold the first and second XOFF bytes, which appear on `cfg_xoff_o`.
- R10: When `rd_i` is low, `rdata_o` is 0x00.
- R11: The enhanced bank opens only for line control exactly 0xBF. Any other value with bit 7 set (for example 0xBE) keeps the normal view of slots 2 and 4..7.
- R12: If `rd_i` and `wr_i` are both high, the access is a write: no receive-pop strobe fires and `rdata_o` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | 6 | Word address bits A6..A1 |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| wdata_i | input | 8 | Write byte (low lane) |
| rdata_o | output | 8 | Read byte (low lane), combinational |
| rx_byte_i | input | 64 | Receive byte per channel, channel p in bits 8p+7..8p |
| isr_i | input | 64 | Interrupt-status byte per channel |
| lsr_i | input | 64 | Line-status byte per channel |
| msr_i | input | 64 | Modem-status byte per channel |
| rx_pop_o | output | 8 | Receive-pop strobe per channel |
| tx_push_o | output | 8 | Transmit-push strobe per channel |
| fifo_wr_o | output | 8 | FIFO-control write strobe per channel |
| tx_byte_o | output | 8 | Byte carried with the push and FIFO strobes |
| cfg_lcr_o | output | 64 | Line-control byte per channel |
| cfg_ier_o | output | 64 | Interrupt-enable byte per channel |
| cfg_mcr_o | output | 64 | Modem-control byte per channel |
| cfg_efr_o | output | 64 | Enhanced-feature byte per channel |
| cfg_div_o | output | 128 | Divisor per channel, 16 bits each |
| cfg_xon_o | output | 128 | XON byte pair per channel |
| cfg_xoff_o | output | 128 | XOFF byte pair per channel |

## Verification
The assertions run on every cycle and cover several fixed behaviours. They check that at most one strobe is active and that a channel which is not written keeps its state. They check that divisor and line-control writes land one cycle later. They also check that no FIFO strobe fires in the 0xBF bank, that no push or pop strobe fires while bit 7 is set, and that read data is zero without a read. The bench scenarios cover what depends on routing and bank values. They show which slot reaches which register or status input, that the 0xBE bank stays normal, and that ignored writes to status slots leave the readback unchanged. They also cover the reset contents across all eight channels and the precedence of a write when both strobes are high.

// File: rtl/uart_bank_pkg.sv
package uart_bank_pkg;

    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned SLOT_W   = 3;
    localparam logic [7:0]  BANK_KEY = 8'hBF;

    typedef enum logic [4:0] {
        SEL_RBR,
        SEL_THR,
        SEL_DLL,
        SEL_DLM,
        SEL_IER,
        SEL_ISR,
        SEL_FCR,
        SEL_EFR,
        SEL_LCR,
        SEL_MCR,
        SEL_LSR,
        SEL_MSR,
        SEL_SCR,
        SEL_XON1,
        SEL_XON2,
        SEL_XOFF1,
        SEL_XOFF2
    } reg_sel_e;

    typedef struct packed {
        logic [BYTE_W-1:0] lcr;
        logic [BYTE_W-1:0] ier;
        logic [BYTE_W-1:0] mcr;
        logic [BYTE_W-1:0] dll;
        logic [BYTE_W-1:0] dlm;
        logic [BYTE_W-1:0] efr;
        logic [BYTE_W-1:0] xon1;
        logic [BYTE_W-1:0] xon2;
        logic [BYTE_W-1:0] xoff1;
        logic [BYTE_W-1:0] xoff2;
        logic [BYTE_W-1:0] scr;
    } port_regs_t;

endpackage

// File: rtl/uart_bank_decode.sv
module uart_bank_decode
    import uart_bank_pkg::*;
(
    input  logic [SLOT_W-1:0] slot_i,
    input  logic              wr_i,
    input  logic [BYTE_W-1:0] lcr_i,
    output reg_sel_e          sel_o
);

    logic dlab;
    logic bank;

    always_comb begin
        dlab = lcr_i[7];
        bank = (lcr_i == BANK_KEY);
        sel_o = SEL_LCR;
        unique case (slot_i)
            3'd0: sel_o = dlab ? SEL_DLL : (wr_i ? SEL_THR : SEL_RBR);
            3'd1: sel_o = dlab ? SEL_DLM : SEL_IER;
            3'd2: sel_o = bank ? SEL_EFR : (wr_i ? SEL_FCR : SEL_ISR);
            3'd3: sel_o = SEL_LCR;
            3'd4: sel_o = bank ? SEL_XON1 : SEL_MCR;
            3'd5: sel_o = bank ? SEL_XON2 : SEL_LSR;
            3'd6: sel_o = bank ? SEL_XOFF1 : SEL_MSR;
            3'd7: sel_o = bank ? SEL_XOFF2 : SEL_SCR;
            default: sel_o = SEL_LCR;
        endcase
    end

endmodule

// File: rtl/uart_bank_port.sv
module uart_bank_port
    import uart_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  reg_sel_e          sel_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic [BYTE_W-1:0] rx_byte_i,
    input  logic [BYTE_W-1:0] isr_i,
    input  logic [BYTE_W-1:0] lsr_i,
    input  logic [BYTE_W-1:0] msr_i,
    output logic [BYTE_W-1:0] rdata_o,
    output port_regs_t        regs_o
);

    port_regs_t state_d;
    port_regs_t state_q;

    always_comb begin
        state_d = state_q;
        if (we_i) begin
            case (sel_i)
                SEL_LCR:   state_d.lcr   = wdata_i;
                SEL_IER:   state_d.ier   = wdata_i;
                SEL_MCR:   state_d.mcr   = wdata_i;
                SEL_DLL:   state_d.dll   = wdata_i;
                SEL_DLM:   state_d.dlm   = wdata_i;
                SEL_EFR:   state_d.efr   = wdata_i;
                SEL_XON1:  state_d.xon1  = wdata_i;
                SEL_XON2:  state_d.xon2  = wdata_i;
                SEL_XOFF1: state_d.xoff1 = wdata_i;
                SEL_XOFF2: state_d.xoff2 = wdata_i;
                SEL_SCR:   state_d.scr   = wdata_i;
                default:   state_d       = state_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    always_comb begin
        case (sel_i)
            SEL_RBR:   rdata_o = rx_byte_i;
            SEL_ISR:   rdata_o = isr_i;
            SEL_LSR:   rdata_o = lsr_i;
            SEL_MSR:   rdata_o = msr_i;
            SEL_LCR:   rdata_o = state_q.lcr;
            SEL_IER:   rdata_o = state_q.ier;
            SEL_MCR:   rdata_o = state_q.mcr;
            SEL_DLL:   rdata_o = state_q.dll;
            SEL_DLM:   rdata_o = state_q.dlm;
            SEL_EFR:   rdata_o = state_q.efr;
            SEL_XON1:  rdata_o = state_q.xon1;
            SEL_XON2:  rdata_o = state_q.xon2;
            SEL_XOFF1: rdata_o = state_q.xoff1;
            SEL_XOFF2: rdata_o = state_q.xoff2;
            SEL_SCR:   rdata_o = state_q.scr;
            default:   rdata_o = '0;
        endcase
    end

    assign regs_o = state_q;

    AST_IDLE_PORT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(state_q)); // R2

    AST_DLL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && sel_i == SEL_DLL) |=> (regs_o.dll == $past(wdata_i))); // R4

    AST_LCR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && sel_i == SEL_LCR) |=> (regs_o.lcr == $past(wdata_i))); // R7

endmodule

// File: rtl/uart_bank_regfile.sv
module uart_bank_regfile
    import uart_bank_pkg::*;
#(
    parameter int unsigned NPORT = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [PORT_W+SLOT_W:1]      addr_i,
    input  logic                        rd_i,
    input  logic                        wr_i,
    input  logic [BYTE_W-1:0]           wdata_i,
    output logic [BYTE_W-1:0]           rdata_o,
    input  logic [NPORT*BYTE_W-1:0]     rx_byte_i,
    input  logic [NPORT*BYTE_W-1:0]     isr_i,
    input  logic [NPORT*BYTE_W-1:0]     lsr_i,
    input  logic [NPORT*BYTE_W-1:0]     msr_i,
    output logic [NPORT-1:0]            rx_pop_o,
    output logic [NPORT-1:0]            tx_push_o,
    output logic [NPORT-1:0]            fifo_wr_o,
    output logic [BYTE_W-1:0]           tx_byte_o,
    output logic [NPORT*BYTE_W-1:0]     cfg_lcr_o,
    output logic [NPORT*BYTE_W-1:0]     cfg_ier_o,
    output logic [NPORT*BYTE_W-1:0]     cfg_mcr_o,
    output logic [NPORT*BYTE_W-1:0]     cfg_efr_o,
    output logic [NPORT*2*BYTE_W-1:0]   cfg_div_o,
    output logic [NPORT*2*BYTE_W-1:0]   cfg_xon_o,
    output logic [NPORT*2*BYTE_W-1:0]   cfg_xoff_o
);

    localparam int unsigned PORT_W = (NPORT > 1) ? $clog2(NPORT) : 1;
    localparam int unsigned WORD_W = 2 * BYTE_W;

    logic [SLOT_W-1:0] slot;
    logic [PORT_W-1:0] pidx;
    logic              rd_active;
    logic [BYTE_W-1:0] lcr_cur;
    reg_sel_e          sel;

    logic [BYTE_W-1:0] lcr_all   [NPORT];
    logic [BYTE_W-1:0] rdata_all [NPORT];
    port_regs_t        regs_all  [NPORT];

    assign slot      = addr_i[SLOT_W:1];
    assign pidx      = addr_i[PORT_W+SLOT_W:SLOT_W+1];
    assign rd_active = rd_i && !wr_i;
    assign lcr_cur   = lcr_all[pidx];
    assign tx_byte_o = wdata_i;

    uart_bank_decode i_decode (
        .slot_i (slot),
        .wr_i   (wr_i),
        .lcr_i  (lcr_cur),
        .sel_o  (sel)
    );

    for (genvar gi = 0; gi < NPORT; gi++) begin : g_port
        logic hit;
        assign hit = (pidx == PORT_W'(gi));

        uart_bank_port i_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .we_i      (wr_i && hit),
            .sel_i     (sel),
            .wdata_i   (wdata_i),
            .rx_byte_i (rx_byte_i[gi*BYTE_W +: BYTE_W]),
            .isr_i     (isr_i[gi*BYTE_W +: BYTE_W]),
            .lsr_i     (lsr_i[gi*BYTE_W +: BYTE_W]),
            .msr_i     (msr_i[gi*BYTE_W +: BYTE_W]),
            .rdata_o   (rdata_all[gi]),
            .regs_o    (regs_all[gi])
        );

        assign lcr_all[gi] = regs_all[gi].lcr;

        assign rx_pop_o[gi]  = rd_active && hit && (sel == SEL_RBR);
        assign tx_push_o[gi] = wr_i && hit && (sel == SEL_THR);
        assign fifo_wr_o[gi] = wr_i && hit && (sel == SEL_FCR);

        assign cfg_lcr_o[gi*BYTE_W +: BYTE_W]  = regs_all[gi].lcr;
        assign cfg_ier_o[gi*BYTE_W +: BYTE_W]  = regs_all[gi].ier;
        assign cfg_mcr_o[gi*BYTE_W +: BYTE_W]  = regs_all[gi].mcr;
        assign cfg_efr_o[gi*BYTE_W +: BYTE_W]  = regs_all[gi].efr;
        assign cfg_div_o[gi*WORD_W +: WORD_W]  = {regs_all[gi].dlm,   regs_all[gi].dll};
        assign cfg_xon_o[gi*WORD_W +: WORD_W]  = {regs_all[gi].xon2,  regs_all[gi].xon1};
        assign cfg_xoff_o[gi*WORD_W +: WORD_W] = {regs_all[gi].xoff2, regs_all[gi].xoff1};
    end

    assign rdata_o = rd_active ? rdata_all[pidx] : '0;

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_pop_o, tx_push_o, fifo_wr_o})); // R2

    AST_BANK_NO_FIFO: assert property (@(posedge clk) disable iff (!rst_n)
        (lcr_cur == BANK_KEY) |-> (fifo_wr_o == '0)); // R6

    AST_DLAB_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        lcr_cur[7] |-> (tx_push_o == '0 && rx_pop_o == '0)); // R4

    AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |-> (rdata_o == '0)); // R10

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && wr_i) |-> (rx_pop_o == '0 && rdata_o == '0)); // R12

endmodule

// File: tb/test_uart_bank_regfile.sv
`timescale 1ns/1ps
module test_uart_bank_regfile;

    localparam int NP = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [6:1]    addr = '0;
    logic          rd = 1'b0;
    logic          wr = 1'b0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata;
    logic [NP*8-1:0] rx_byte, isr, lsr, msr;
    logic [NP-1:0] rx_pop, tx_push, fifo_wr;
    logic [7:0]    tx_byte;
    logic [NP*8-1:0]  cfg_lcr, cfg_ier, cfg_mcr, cfg_efr;
    logic [NP*16-1:0] cfg_div, cfg_xon, cfg_xoff;

    int n_checks = 0;
    int n_errors = 0;

    logic [NP-1:0] cap_pop, cap_push, cap_fifo;
    logic [7:0]    cap_tx;

    always #2.5 clk = ~clk;

    uart_bank_regfile #(.NPORT(NP)) i_uart_bank_regfile (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr),
        .wdata_i(wdata), .rdata_o(rdata),
        .rx_byte_i(rx_byte), .isr_i(isr), .lsr_i(lsr), .msr_i(msr),
        .rx_pop_o(rx_pop), .tx_push_o(tx_push), .fifo_wr_o(fifo_wr),
        .tx_byte_o(tx_byte),
        .cfg_lcr_o(cfg_lcr), .cfg_ier_o(cfg_ier), .cfg_mcr_o(cfg_mcr),
        .cfg_efr_o(cfg_efr), .cfg_div_o(cfg_div), .cfg_xon_o(cfg_xon),
        .cfg_xoff_o(cfg_xoff)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input int p, input int slot, input logic [7:0] d);
        @(negedge clk);
        addr  = {p[2:0], slot[2:0]};
        wdata = d;
        wr    = 1'b1;
        #1;
        cap_pop = rx_pop; cap_push = tx_push; cap_fifo = fifo_wr; cap_tx = tx_byte;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_rd(input int p, input int slot, output logic [7:0] v);
        @(negedge clk);
        addr = {p[2:0], slot[2:0]};
        rd   = 1'b1;
        #1;
        v = rdata;
        cap_pop = rx_pop; cap_push = tx_push; cap_fifo = fifo_wr;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        for (int p = 0; p < NP; p++) begin
            bus_rd(p, 3, v); chk("R1 lcr", v, 0);
            bus_rd(p, 1, v); chk("R1 ier", v, 0);
            bus_rd(p, 4, v); chk("R1 mcr", v, 0);
            bus_rd(p, 7, v); chk("R1 scr", v, 0);
        end
        chk("R1 cfg_lcr", cfg_lcr[31:0], 0);
        chk("R1 cfg_div", cfg_div[31:0], 0);
        chk("R1 cfg_xon", cfg_xon[31:0], 0);
    endtask

    task automatic t_port_select;
        logic [7:0] v;
        for (int p = 0; p < NP; p++) bus_wr(p, 7, 8'h10 + 8'(p));
        for (int p = 0; p < NP; p++) begin
            bus_rd(p, 7, v); chk("R2 scr per port", v, 8'h10 + 8'(p));
        end
        bus_wr(4, 1, 8'h5A);
        chk("R2 ier port4", cfg_ier[4*8 +: 8], 8'h5A);
        chk("R2 ier port3 untouched", cfg_ier[3*8 +: 8], 0);
        chk("R2 ier port5 untouched", cfg_ier[5*8 +: 8], 0);
        bus_wr(4, 1, 8'h00);
    endtask

    task automatic t_data_slot;
        logic [7:0] v;
        bus_rd(3, 0, v);
        chk("R3 rbr data", v, 8'hA3);
        chk("R3 pop strobe", cap_pop, 8'b0000_1000);
        bus_wr(5, 0, 8'h77);
        chk("R3 push strobe", cap_push, 8'b0010_0000);
        chk("R3 tx byte", cap_tx, 8'h77);
        chk("R3 no fifo", cap_fifo, 0);
    endtask

    task automatic t_divisor;
        logic [7:0] v;
        bus_wr(2, 3, 8'h80);
        bus_wr(2, 0, 8'h34);
        chk("R4 no push under dlab", cap_push, 0);
        bus_wr(2, 1, 8'h12);
        chk("R4 cfg_div", cfg_div[2*16 +: 16], 16'h1234);
        chk("R4 ier kept", cfg_ier[2*8 +: 8], 0);
        bus_rd(2, 0, v); chk("R4 dll read", v, 8'h34);
        chk("R4 no pop", cap_pop, 0);
        bus_rd(2, 1, v); chk("R4 dlm read", v, 8'h12);
        bus_wr(2, 3, 8'hBF);
        bus_rd(2, 0, v); chk("R4 dll in BF", v, 8'h34);
        bus_wr(2, 3, 8'h00);
        bus_rd(2, 0, v); chk("R4 rbr back", v, 8'hA2);
    endtask

    task automatic t_ier;
        logic [7:0] v;
        bus_wr(1, 1, 8'h0F);
        bus_rd(1, 1, v); chk("R5 ier read", v, 8'h0F);
        chk("R5 div untouched", cfg_div[1*16 +: 16], 0);
    endtask

    task automatic t_status_fifo;
        logic [7:0] v;
        bus_rd(0, 2, v); chk("R6 isr read", v, 8'hC0);
        bus_wr(0, 2, 8'h07); chk("R6 fifo strobe", cap_fifo, 8'b0000_0001);
        bus_wr(0, 3, 8'hBF);
        bus_wr(0, 2, 8'hD0); chk("R6 no fifo in BF", cap_fifo, 0);
        bus_rd(0, 2, v); chk("R6 efr read", v, 8'hD0);
        chk("R6 cfg_efr", cfg_efr[7:0], 8'hD0);
        bus_rd(0, 3, v); chk("R7 lcr readable in BF", v, 8'hBF);
    endtask

    task automatic t_lcr;
        logic [7:0] v;
        bus_wr(7, 3, 8'h9B);
        bus_rd(7, 3, v); chk("R7 lcr read", v, 8'h9B);
        bus_wr(7, 3, 8'h03);
        chk("R7 cfg_lcr", cfg_lcr[7*8 +: 8], 8'h03);
    endtask

    task automatic t_modem_xon;
        logic [7:0] v;
        bus_wr(3, 4, 8'h0B);
        bus_rd(3, 4, v); chk("R8 mcr", v, 8'h0B);
        bus_wr(3, 5, 8'hFF);
        bus_rd(3, 5, v); chk("R8 lsr input, write ignored", v, 8'h63);
        bus_wr(3, 3, 8'hBF);
        bus_wr(3, 4, 8'h11);
        bus_wr(3, 5, 8'h13);
        chk("R8 cfg_xon", cfg_xon[3*16 +: 16], 16'h1311);
        bus_rd(3, 4, v); chk("R8 xon1", v, 8'h11);
        chk("R8 mcr kept", cfg_mcr[3*8 +: 8], 8'h0B);
        bus_wr(3, 3, 8'h00);
    endtask

    task automatic t_msr_xoff;
        logic [7:0] v;
        bus_wr(6, 6, 8'hEE);
        bus_rd(6, 6, v); chk("R9 msr input, write ignored", v, 8'h96);
        bus_wr(6, 7, 8'h42);
        bus_wr(6, 3, 8'hBF);
        bus_wr(6, 6, 8'h19);
        bus_wr(6, 7, 8'h93);
        chk("R9 cfg_xoff", cfg_xoff[6*16 +: 16], 16'h9319);
        bus_rd(6, 7, v); chk("R9 xoff2", v, 8'h93);
        bus_wr(6, 3, 8'h00);
        bus_rd(6, 7, v); chk("R9 scr kept", v, 8'h42);
    endtask

    task automatic t_idle;
        @(negedge clk);
        addr = {3'd6, 3'd7};
        #1;
        chk("R10 idle rdata", rdata, 0);
    endtask

    task automatic t_exact_key;
        logic [7:0] v;
        bus_wr(5, 3, 8'hBE);
        bus_wr(5, 4, 8'h33);
        bus_rd(5, 4, v); chk("R11 mcr under BE", v, 8'h33);
        bus_wr(5, 2, 8'h01); chk("R11 fifo under BE", cap_fifo, 8'b0010_0000);
        chk("R11 efr untouched", cfg_efr[5*8 +: 8], 0);
        bus_rd(5, 0, v); chk("R11 dll under BE", v, 0);
        bus_wr(5, 3, 8'hBF);
        bus_rd(5, 4, v); chk("R11 xon1 under BF", v, 0);
        bus_wr(5, 3, 8'h00);
    endtask

    task automatic t_both;
        @(negedge clk);
        addr = {3'd1, 3'd0}; wdata = 8'h5C; rd = 1'b1; wr = 1'b1;
        #1;
        chk("R12 no pop", rx_pop, 0);
        chk("R12 push", tx_push, 8'b0000_0010);
        chk("R12 rdata zero", rdata, 0);
        @(negedge clk);
        rd = 1'b0; wr = 1'b0;
    endtask

    initial begin
        for (int p = 0; p < NP; p++) begin
            rx_byte[p*8 +: 8] = 8'hA0 + 8'(p);
            isr[p*8 +: 8]     = 8'hC0 + 8'(p);
            lsr[p*8 +: 8]     = 8'h60 + 8'(p);
            msr[p*8 +: 8]     = 8'h90 + 8'(p);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_port_select;
        t_data_slot;
        t_divisor;
        t_ier;
        t_status_fifo;
        t_lcr;
        t_modem_xon;
        t_msr_xoff;
        t_idle;
        t_exact_key;
        t_both;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #200000;
        n_errors++;
        n_checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule